// File: doc/BRIEF.md
# Microcode Step Sequencer

This block steps through the micro-instructions of a small 8-bit processor. It holds the instruction register, a step counter and an interrupt flag. From these three it forms a lookup address, reads a 16-bit control word from an internal table, and breaks that word into one-hot strobes. The strobes choose what drives the read bus, which register takes the write bus, which source drives the address, and where the incremented address goes. The same word also carries two load bits that leave the block without decoding. The datapath sits outside the block.

Every instruction ends with a step that sets a "final" bit in its word. That step also fetches the next opcode. On the following clock the counter goes back to 0, and the interrupt flag takes the value of the interrupt request. While the flag is set, the first step looks up opcode 0x00. The instruction register is not used for that lookup. In that same step the instruction register can capture a value from the write bus. After reset the interrupt sequence runs first, which fetches the start vector.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is asserted, the step is 0, the interrupt flag is 1 and the presented opcode is 0x00. The first sequence to run after reset is therefore the interrupt sequence.
- R2: While the interrupt flag is set and the step is 0, the opcode presented and used for lookup is 0x00. At every final step the flag loads the interrupt request input.
- R3: If the final bit is set, the step returns to 0 on the next clock. Otherwise the step increments by one.
- R4: The instruction register loads only when the IR-load bit is set. It takes the write bus when the interrupt flag is set and the step is 0, and the data bus in every other case. When the step is above 0 it is presented as the opcode.
- R5: The 4-bit read select is decoded into 16 one-hot lines, with line n standing for code n. Code 0 is idle, 1 is the accumulator, 6 is the status byte with B=0, 7 is the status byte with B=1, 8 is the low PC byte and 9 is the high PC byte.
- R6: Write-select codes 0 to 14 drive one-hot line n of the write strobes, with 0 meaning idle and 11 the low pointer byte. Code 15 drives only the memory-write strobe and leaves all 15 lines low.
- R7: The data-bus drive enable is high exactly when the memory-write strobe and the bus enable are both high.
- R8: Address-select codes 0 to 5 drive one-hot line n: pointer, PC, stack, zero-page pointer, top-page pointer, pointer-high/temp. Increment codes 1 to 3 drive line n-1 (to PC, to pointer low, to stack). Code 0 drives no increment line.
- R9: The IR-load and pointer-high-load bits reach their outputs without decoding.
- R10: Any opcode without a table entry runs one step. That step has address select 1, increment code 1, IR-load set and the final bit set.
- R11: The interrupt sequence is 6 steps long, using read/write/address/increment codes. Steps 0 to 2 each write to memory at address 2 with increment 3, reading codes 9, 8 and 6. Step 0 also sets IR-load. Step 3 is write 11, address 4, increment 2. Step 4 is address 4 with pointer-high load. Step 5 is address 0, increment 1, IR-load, final.
- R12: Opcode 0xEA takes 2 steps: address 1, then a fetch step. Opcode 0x4C takes 3 steps: write 11 at address 1 with increment 1, then address 1 with pointer-high load, then address 0 with increment 1, IR-load and final.
- R13: Opcode 0x08 takes 3 steps: address 1, then read 7 with write 15 at address 2 and increment 3, then a fetch step. Opcode 0x85 takes 3 steps: write 11 at address 1 with increment 1, then read 1 with write 15 at address 3, then a fetch step. A fetch step means address 1, increment 1, IR-load and final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_req | input | 1 | Interrupt request, sampled at each final step |
| dbus_in | input | OP_W | External data bus, opcode fetch source |
| wbus_in | input | OP_W | Internal write bus, IR source during interrupt entry |
| bus_en | input | 1 | Bus enable from outside |
| step_q | output | STEP_W | Current micro-step |
| int_active | output | 1 | Interrupt flag |
| opcode_out | output | OP_W | Opcode presented to the table |
| rd_oh | output | 16 | One-hot read-bus source |
| wr_oh | output | 15 | One-hot register write strobes |
| mem_wr | output | 1 | Memory-write strobe |
| db_drive | output | 1 | Data-bus driver enable |
| ad_oh | output | AD_N | One-hot address source |
| inc_oh | output | 3 | One-hot increment destination |
| ir_ld | output | 1 | Raw IR-load bit |
| dph_ld | output | 1 | Raw pointer-high load bit |
| step_last | output | 1 | Final-step bit |

## Verification
The bench builds the block with its defaults: a 3-bit step, an 8-bit opcode and six address sources. With these values every table entry can be reached, including the 6-step interrupt sequence. Undefined opcodes 0x02, 0x13, 0xFF and 0x00 are fed in as well. Interrupt requests are raised in windows that overlap final steps of different instructions, so both the back-to-back interrupt path and the normal fetch path occur. The write bus changes every cycle, which shows which bus the instruction register loaded from.

// File: rtl/useq_pkg.sv
package useq_pkg;
   localparam int RD_W  = 4;
   localparam int WR_W  = 4;
   localparam int AD_W  = 3;
   localparam int INC_W = 2;
   localparam int CW_W  = 16;

   localparam logic [RD_W-1:0] RD_IDLE = 4'd0;
   localparam logic [RD_W-1:0] RD_ACC  = 4'd1;
   localparam logic [RD_W-1:0] RD_PB0  = 4'd6;
   localparam logic [RD_W-1:0] RD_PB1  = 4'd7;
   localparam logic [RD_W-1:0] RD_PCL  = 4'd8;
   localparam logic [RD_W-1:0] RD_PCH  = 4'd9;

   localparam logic [WR_W-1:0] WR_IDLE = 4'd0;
   localparam logic [WR_W-1:0] WR_PTRL = 4'd11;
   localparam logic [WR_W-1:0] WR_MEM  = 4'd15;

   localparam logic [AD_W-1:0] AD_PTR  = 3'd0;
   localparam logic [AD_W-1:0] AD_PC   = 3'd1;
   localparam logic [AD_W-1:0] AD_STK  = 3'd2;
   localparam logic [AD_W-1:0] AD_ZPG  = 3'd3;
   localparam logic [AD_W-1:0] AD_TOP  = 3'd4;

   localparam logic [INC_W-1:0] INC_NONE = 2'd0;
   localparam logic [INC_W-1:0] INC_PC   = 2'd1;
   localparam logic [INC_W-1:0] INC_PTRL = 2'd2;
   localparam logic [INC_W-1:0] INC_STK  = 2'd3;

   typedef struct packed {
      logic [RD_W-1:0]  rd;
      logic [WR_W-1:0]  wr;
      logic [AD_W-1:0]  ad;
      logic [INC_W-1:0] inc;
      logic             irld;
      logic             dphld;
      logic             fin;
   } ctrl_t;

   function automatic ctrl_t mk(input logic [RD_W-1:0] r, input logic [WR_W-1:0] w,
                                input logic [AD_W-1:0] a, input logic [INC_W-1:0] i,
                                input logic il, input logic dl, input logic f);
      ctrl_t c;
      c.rd = r; c.wr = w; c.ad = a; c.inc = i;
      c.irld = il; c.dphld = dl; c.fin = f;
      return c;
   endfunction
endpackage

// File: rtl/useq_state.sv
module useq_state #(
   parameter int STEP_W = 3,
   parameter int OP_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fin,
   input  logic              irld,
   input  logic              int_req,
   input  logic [OP_W-1:0]   dbus_in,
   input  logic [OP_W-1:0]   wbus_in,
   output logic [STEP_W-1:0] q,
   output logic              int_q,
   output logic [OP_W-1:0]   ir,
   output logic              entry
);
   assign entry = int_q && (q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q     <= '0;
         int_q <= 1'b1;
         ir    <= '0;
      end else begin
         if (fin) begin
            q     <= '0;
            int_q <= int_req;
         end else begin
            q <= q + 1'b1;
         end
         if (irld) ir <= entry ? wbus_in : dbus_in;
      end
   end

   assert_final_resets_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (q == '0));
   assert_step_advances_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> (q == $past(q) + 1'b1));
   assert_ir_from_wbus_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irld && int_q && q == '0) |=> (ir == $past(wbus_in)));
   assert_ir_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !irld |=> $stable(ir));
endmodule

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int STEP_W = 3,
   parameter int OP_W   = 8
) (
   input  logic              int_flag,
   input  logic [OP_W-1:0]   op,
   input  logic [STEP_W-1:0] q,
   output ctrl_t             cw
);
   localparam int ADDR_W = 1 + OP_W + STEP_W;

   logic [ADDR_W-1:0] addr;
   assign addr = {int_flag, op, q};

   ctrl_t fetch;
   assign fetch = mk(RD_IDLE, WR_IDLE, AD_PC, INC_PC, 1'b1, 1'b0, 1'b1);

   always_comb begin
      cw = fetch;
      if (addr[ADDR_W-1]) begin
         case (int'(addr[STEP_W-1:0]))
            0: cw = mk(RD_PCH, WR_MEM, AD_STK, INC_STK, 1'b1, 1'b0, 1'b0);
            1: cw = mk(RD_PCL, WR_MEM, AD_STK, INC_STK, 1'b0, 1'b0, 1'b0);
            2: cw = mk(RD_PB0, WR_MEM, AD_STK, INC_STK, 1'b0, 1'b0, 1'b0);
            3: cw = mk(RD_IDLE, WR_PTRL, AD_TOP, INC_PTRL, 1'b0, 1'b0, 1'b0);
            4: cw = mk(RD_IDLE, WR_IDLE, AD_TOP, INC_NONE, 1'b0, 1'b1, 1'b0);
            5: cw = mk(RD_IDLE, WR_IDLE, AD_PTR, INC_PC, 1'b1, 1'b0, 1'b1);
            default: cw = fetch;
         endcase
      end else begin
         case (addr[STEP_W +: OP_W])
            OP_W'(8'hEA): if (int'(addr[STEP_W-1:0]) == 0)
               cw = mk(RD_IDLE, WR_IDLE, AD_PC, INC_NONE, 1'b0, 1'b0, 1'b0);
            OP_W'(8'h4C): case (int'(addr[STEP_W-1:0]))
               0: cw = mk(RD_IDLE, WR_PTRL, AD_PC, INC_PC, 1'b0, 1'b0, 1'b0);
               1: cw = mk(RD_IDLE, WR_IDLE, AD_PC, INC_NONE, 1'b0, 1'b1, 1'b0);
               default: cw = mk(RD_IDLE, WR_IDLE, AD_PTR, INC_PC, 1'b1, 1'b0, 1'b1);
            endcase
            OP_W'(8'h08): case (int'(addr[STEP_W-1:0]))
               0: cw = mk(RD_IDLE, WR_IDLE, AD_PC, INC_NONE, 1'b0, 1'b0, 1'b0);
               1: cw = mk(RD_PB1, WR_MEM, AD_STK, INC_STK, 1'b0, 1'b0, 1'b0);
               default: cw = fetch;
            endcase
            OP_W'(8'h85): case (int'(addr[STEP_W-1:0]))
               0: cw = mk(RD_IDLE, WR_PTRL, AD_PC, INC_PC, 1'b0, 1'b0, 1'b0);
               1: cw = mk(RD_ACC, WR_MEM, AD_ZPG, INC_NONE, 1'b0, 1'b0, 1'b0);
               default: cw = fetch;
            endcase
            default: cw = fetch;
         endcase
      end
   end
endmodule

// File: rtl/useq_onehot.sv
module useq_onehot #(
   parameter int SEL_W = 4,
   parameter int FIRST = 0,
   parameter int N     = 16
) (
   input  logic [SEL_W-1:0] sel,
   output logic [N-1:0]     lines
);
   if (FIRST + N > (1 << SEL_W)) begin : g_bad_range
      $error("useq_onehot: line range exceeds select code space");
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      assign lines[i] = (sel == SEL_W'(FIRST + i));
   end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
   import useq_pkg::*;
#(
   parameter int STEP_W = 3,
   parameter int OP_W   = 8,
   parameter int AD_N   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_req,
   input  logic [OP_W-1:0]   dbus_in,
   input  logic [OP_W-1:0]   wbus_in,
   input  logic              bus_en,
   output logic [STEP_W-1:0] step_q,
   output logic              int_active,
   output logic [OP_W-1:0]   opcode_out,
   output logic [15:0]       rd_oh,
   output logic [14:0]       wr_oh,
   output logic              mem_wr,
   output logic              db_drive,
   output logic [AD_N-1:0]   ad_oh,
   output logic [2:0]        inc_oh,
   output logic              ir_ld,
   output logic              dph_ld,
   output logic              step_last
);
   localparam int RD_N  = 1 << RD_W;
   localparam int WR_N  = (1 << WR_W) - 1;
   localparam int INC_N = (1 << INC_W) - 1;

   if (STEP_W < 3) begin : g_bad_step
      $error("ucode_sequencer: STEP_W must hold the 6-step interrupt sequence");
   end
   if (OP_W < 8) begin : g_bad_op
      $error("ucode_sequencer: OP_W must hold 8-bit opcodes");
   end
   if (AD_N > (1 << AD_W) || AD_N < 6) begin : g_bad_ad
      $error("ucode_sequencer: AD_N out of range");
   end
   if ($bits(ctrl_t) != CW_W) begin : g_bad_cw
      $error("ucode_sequencer: control word width mismatch");
   end

   ctrl_t           cw;
   logic [OP_W-1:0] ir;
   logic            entry;

   useq_state #(.STEP_W(STEP_W), .OP_W(OP_W)) u_state (
      .clk(clk), .rst_n(rst_n), .fin(cw.fin), .irld(cw.irld), .int_req(int_req),
      .dbus_in(dbus_in), .wbus_in(wbus_in), .q(step_q), .int_q(int_active),
      .ir(ir), .entry(entry)
   );

   assign opcode_out = entry ? '0 : ir;

   useq_store #(.STEP_W(STEP_W), .OP_W(OP_W)) u_store (
      .int_flag(int_active), .op(opcode_out), .q(step_q), .cw(cw)
   );

   useq_onehot #(.SEL_W(RD_W), .FIRST(0), .N(RD_N)) u_rd (.sel(cw.rd), .lines(rd_oh));
   useq_onehot #(.SEL_W(WR_W), .FIRST(0), .N(WR_N)) u_wr (.sel(cw.wr), .lines(wr_oh));
   useq_onehot #(.SEL_W(AD_W), .FIRST(0), .N(AD_N)) u_ad (.sel(cw.ad), .lines(ad_oh));
   useq_onehot #(.SEL_W(INC_W), .FIRST(1), .N(INC_N)) u_inc (.sel(cw.inc), .lines(inc_oh));

   assign mem_wr    = (cw.wr == WR_MEM);
   assign db_drive  = mem_wr && bus_en;
   assign ir_ld     = cw.irld;
   assign dph_ld    = cw.dphld;
   assign step_last = cw.fin;

   assert_int_entry_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_last && int_req) |=> (opcode_out == '0));
   assert_rd_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_oh) == 1);
   assert_mem_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (wr_oh == '0));
   assert_wr_covered_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr |-> ($countones(wr_oh) == 1));
   assert_drive_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      db_drive |-> (mem_wr && bus_en));
   assert_ad_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ad_oh) && $onehot0(inc_oh));
endmodule

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        int_req;
   logic [7:0]  dbus_in, wbus_in;
   logic        bus_en;
   logic [2:0]  step_q;
   logic        int_active;
   logic [7:0]  opcode_out;
   logic [15:0] rd_oh;
   logic [14:0] wr_oh;
   logic        mem_wr, db_drive;
   logic [5:0]  ad_oh;
   logic [2:0]  inc_oh;
   logic        ir_ld, dph_ld, step_last;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   ucode_sequencer u_ucode_sequencer (
      .clk(clk), .rst_n(rst_n), .int_req(int_req), .dbus_in(dbus_in),
      .wbus_in(wbus_in), .bus_en(bus_en), .step_q(step_q), .int_active(int_active),
      .opcode_out(opcode_out), .rd_oh(rd_oh), .wr_oh(wr_oh), .mem_wr(mem_wr),
      .db_drive(db_drive), .ad_oh(ad_oh), .inc_oh(inc_oh), .ir_ld(ir_ld),
      .dph_ld(dph_ld), .step_last(step_last)
   );

   // expected word: {rd[4], wr[4], ad[3], inc[2], irld, dphld, fin}
   function automatic logic [15:0] w(int r, int wr, int a, int i, int il, int dl, int f);
      return {4'(r), 4'(wr), 3'(a), 2'(i), 1'(il), 1'(dl), 1'(f)};
   endfunction

   function automatic logic [15:0] spec(bit intf, logic [7:0] op, int q);
      logic [15:0] fetch = w(0, 0, 1, 1, 1, 0, 1);
      if (intf) begin
         case (q)
            0: return w(9, 15, 2, 3, 1, 0, 0);
            1: return w(8, 15, 2, 3, 0, 0, 0);
            2: return w(6, 15, 2, 3, 0, 0, 0);
            3: return w(0, 11, 4, 2, 0, 0, 0);
            4: return w(0, 0, 4, 0, 0, 1, 0);
            5: return w(0, 0, 0, 1, 1, 0, 1);
            default: return fetch;
         endcase
      end
      case (op)
         8'hEA: return (q == 0) ? w(0, 0, 1, 0, 0, 0, 0) : fetch;
         8'h4C: return (q == 0) ? w(0, 11, 1, 1, 0, 0, 0) :
                       (q == 1) ? w(0, 0, 1, 0, 0, 1, 0) : w(0, 0, 0, 1, 1, 0, 1);
         8'h08: return (q == 0) ? w(0, 0, 1, 0, 0, 0, 0) :
                       (q == 1) ? w(7, 15, 2, 3, 0, 0, 0) : fetch;
         8'h85: return (q == 0) ? w(0, 11, 1, 1, 0, 0, 0) :
                       (q == 1) ? w(1, 15, 3, 0, 0, 0, 0) : fetch;
         default: return fetch;
      endcase
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model state
   bit          m_int;
   int          m_q;
   logic [7:0]  m_ir;

   task automatic compare_all();
      logic [7:0]  op = (m_int && m_q == 0) ? 8'h00 : m_ir;
      logic [15:0] e  = spec(m_int, op, m_q);
      int r = e[15:12], wr = e[11:8], a = e[7:5], i = e[4:3];
      string tag;
      if (m_int) tag = "R11";
      else if (op == 8'hEA || op == 8'h4C) tag = "R12";
      else if (op == 8'h08 || op == 8'h85) tag = "R13";
      else tag = "R10";
      chk("R3", "step", 32'(step_q), 32'(m_q));
      chk("R2", "int flag", 32'(int_active), 32'(m_int));
      chk("R4", "opcode", 32'(opcode_out), 32'(op));
      chk("R5", "read lines", 32'(rd_oh), 32'(16'(1) << r));
      chk("R6", "write lines", 32'(wr_oh), (wr == 15) ? 32'd0 : 32'(15'(1) << wr));
      chk("R6", "mem write", 32'(mem_wr), 32'(wr == 15));
      chk("R7", "drive", 32'(db_drive), 32'(wr == 15 && bus_en));
      chk("R8", "addr lines", 32'(ad_oh), (a < 6) ? 32'(6'(1) << a) : 32'd0);
      chk("R8", "inc lines", 32'(inc_oh), (i == 0) ? 32'd0 : 32'(3'(1) << (i - 1)));
      chk("R9", "raw loads", 32'({ir_ld, dph_ld}), 32'(e[2:1]));
      chk(tag, "final bit", 32'(step_last), 32'(e[0]));
   endtask

   localparam int PROG_N = 12;
   logic [7:0] prog [PROG_N] = '{8'hEA, 8'h4C, 8'h08, 8'h85, 8'h02, 8'hFF,
                                 8'h00, 8'hEA, 8'h4C, 8'h08, 8'h85, 8'h13};

   initial begin
      int pidx = 0;
      rst_n = 1'b0; int_req = 1'b0; dbus_in = 8'h00; wbus_in = 8'h00; bus_en = 1'b0;
      m_int = 1'b1; m_q = 0; m_ir = 8'h00;
      repeat (3) begin
         @(negedge clk);
         chk("R1", "reset step", 32'(step_q), 32'd0);
         chk("R1", "reset int flag", 32'(int_active), 32'd1);
         chk("R1", "reset opcode", 32'(opcode_out), 32'h00);
      end
      rst_n = 1'b1;
      for (int cyc = 0; cyc < 400; cyc++) begin
         logic [15:0] e;
         logic [7:0]  op;
         int_req = (cyc >= 40 && cyc < 43) || (cyc >= 150 && cyc < 175);
         wbus_in = 8'(cyc * 37 + 5);
         bus_en  = (cyc % 3) != 1;
         dbus_in = prog[pidx % PROG_N];
         @(posedge clk);
         op = (m_int && m_q == 0) ? 8'h00 : m_ir;
         e  = spec(m_int, op, m_q);
         if (e[2]) begin
            if (m_int && m_q == 0) m_ir = wbus_in;
            else begin
               m_ir = dbus_in;
               pidx++;
            end
         end
         if (e[0]) begin
            m_q = 0;
            m_int = int_req;
         end else begin
            m_q++;
         end
         @(negedge clk);
         compare_all();
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule